// File: doc/BRIEF.md
# Address-Triggered Load/Store Register Unit

This block holds the operand state of a load/store machine: eight 60-bit data registers, eight 18-bit address registers and eight 18-bit index registers. It accepts one pre-decoded request per cycle. A request can set a data register from an immediate word, add a displacement to an index register, or add a displacement to an address register or an index register and write the sum into an address register. All address arithmetic wraps modulo 2^18.

The unit has no load or store requests. Memory traffic is a side effect of writing an address register. Writing address registers 1 to 5 fetches the word at the new address into the data register with the same number. Writing address register 6 or 7 sends the data register with the same number to the new address. Address register 0 is an ordinary pointer with no side effect. At most one transfer is in flight. A request that would start a second transfer is held off through `req_ready`. A separate read port shows all three register files for inspection.

Top module: `addr_trig_lsu`

## Requirements
- R1: After reset every data, address and index register reads zero, `mem_req` is low and `req_ready` is high.
- R2: An accepted request with `req_op` = 0 writes `req_data` into data register `req_i` at the clock edge.
- R3: An accepted request with `req_op` = 1 writes index[`req_j`] + `req_disp` into index register `req_i`. Index register 0 always reads zero, and writes to it have no effect.
- R4: An accepted request with `req_op` = 2 writes address[`req_j`] + `req_disp` into address register `req_i`. With `req_op` = 3 the base is index[`req_j`].
- R5: Writing address register 1 to 5 raises `mem_req` in the next cycle with `mem_we` = 0 and `mem_addr` equal to the new address. On the edge where `mem_ack` is high, `mem_rdata` is written into data register `req_i`.
- R6: Writing address register 6 or 7 raises `mem_req` in the next cycle with `mem_we` = 1, `mem_addr` equal to the new address, and `mem_wdata` equal to that data register's value at the accepting edge.
- R7: Writing address register 0 updates the register and starts no memory transfer.
- R8: While a transfer is pending, `req_ready` is low for two kinds of request: a write to address registers 1 to 7, and a data-register write aimed at the target of the pending load. A request that is not accepted changes no state.
- R9: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until `mem_ack`. `mem_req` falls in the cycle after the acknowledge.
- R10: All sums are taken modulo 2^18. For example, 100 + 0x3FFFF gives 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 set data, 1 index += disp, 2 address from address, 3 address from index |
| req_i | input | 3 | Destination register number |
| req_j | input | 3 | Source register number |
| req_disp | input | 18 | Displacement added to the source |
| req_data | input | 60 | Immediate word for op 0 |
| mem_req | output | 1 | Transfer pending |
| mem_we | output | 1 | 1 store, 0 load |
| mem_addr | output | 18 | Word address |
| mem_wdata | output | 60 | Store data |
| mem_ack | input | 1 | Memory completes the pending transfer |
| mem_rdata | input | 60 | Load data, valid with mem_ack |
| rd_sel | input | 3 | Inspection register number |
| rd_x | output | 60 | Data register rd_sel |
| rd_a | output | 18 | Address register rd_sel |
| rd_b | output | 18 | Index register rd_sel |

## Verification
A behavioural model in the bench runs in lockstep with the design. All 24 registers and the memory port are compared every cycle. Directed runs cover four things: an A0 write, which shows plain pointer updates apart from triggering ones; a stalled load with competing requests, which shows stalled requests apart from independent ones; a store that must capture the pre-edge data; and a wrapping sum. A long random run mixes all four operations with irregular acknowledge timing, so that back-to-back launches, acknowledges and data writes fall in every relative order.

// File: rtl/addr_trig_lsu.sv
module addr_trig_lsu #(
  parameter int DW = 60,
  parameter int AW = 18,
  parameter int NREG = 8,
  parameter int STORE_FROM = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [$clog2(NREG)-1:0] req_i,
  input  logic [$clog2(NREG)-1:0] req_j,
  input  logic [AW-1:0]           req_disp,
  input  logic [DW-1:0]           req_data,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic                    mem_ack,
  input  logic [DW-1:0]           mem_rdata,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic [DW-1:0]           rd_x,
  output logic [AW-1:0]           rd_a,
  output logic [AW-1:0]           rd_b
);
  localparam int IW = $clog2(NREG);
  localparam logic [1:0] OP_SETX  = 2'd0;
  localparam logic [1:0] OP_BINC  = 2'd1;
  localparam logic [1:0] OP_AINCB = 2'd3;

  logic [DW-1:0] xr [NREG];
  logic [AW-1:0] ar [NREG];
  logic [AW-1:0] br [NREG];
  logic          pend;
  logic [IW-1:0] tgt;

  logic          kick, x_clash, take;
  logic [AW-1:0] a_new, b_new;

  assign kick     = req_op[1] && (req_i != '0);
  assign x_clash  = (req_op == OP_SETX) && !mem_we && (req_i == tgt);
  assign req_ready = !pend || !(kick || x_clash);
  assign take     = req_valid && req_ready;
  assign a_new    = ((req_op == OP_AINCB) ? br[req_j] : ar[req_j]) + req_disp;
  assign b_new    = br[req_j] + req_disp;

  assign mem_req = pend;
  assign rd_x = xr[rd_sel];
  assign rd_a = ar[rd_sel];
  assign rd_b = br[rd_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NREG; n++) begin
        xr[n] <= '0;
        ar[n] <= '0;
        br[n] <= '0;
      end
      pend      <= 1'b0;
      tgt       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      if (pend && mem_ack) begin
        pend <= 1'b0;
        if (!mem_we) xr[tgt] <= mem_rdata;
      end
      if (take) begin
        if (req_op == OP_SETX) xr[req_i] <= req_data;
        else if (req_op == OP_BINC) begin
          if (req_i != '0) br[req_i] <= b_new;
        end else ar[req_i] <= a_new;
        if (kick) begin
          pend      <= 1'b1;
          tgt       <= req_i;
          mem_addr  <= a_new;
          mem_we    <= (req_i >= IW'(STORE_FROM));
          mem_wdata <= xr[req_i];
        end
      end
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && req_op[1] && (req_i != '0) |-> !req_ready);

  // R7
  a0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && req_valid && req_op[1] && (req_i == '0) |=> !mem_req);

  // R5 R6
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && req_valid && req_op[1] && (req_i != '0)
    |=> mem_req && (mem_addr == ar[tgt]) && (mem_we == (tgt >= IW'(STORE_FROM))));
endmodule

// File: tb/addr_trig_lsu_tb.sv
`timescale 1ns/10ps
module addr_trig_lsu_tb;
  logic clk = 0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_ready, mem_req, mem_we, mem_ack;
  logic [1:0]  req_op;
  logic [2:0]  req_i, req_j, rd_sel;
  logic [17:0] req_disp, mem_addr, rd_a, rd_b;
  logic [59:0] req_data, mem_wdata, mem_rdata, rd_x;

  addr_trig_lsu u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_i(req_i), .req_j(req_j), .req_disp(req_disp),
    .req_data(req_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rd_sel(rd_sel), .rd_x(rd_x), .rd_a(rd_a), .rd_b(rd_b));

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [59:0] mx [8];
  logic [17:0] ma [8];
  logic [17:0] mb [8];
  bit          mpend, mwe;
  int          mtgt;
  logic [17:0] maddr;
  logic [59:0] mwdata;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #0.2;
      chk($sformatf("R2 data reg %0d", s), 64'(rd_x), 64'(mx[s]));
      chk($sformatf("R4 address reg %0d", s), 64'(rd_a), 64'(ma[s]));
      chk($sformatf("R3 index reg %0d", s), 64'(rd_b), 64'(mb[s]));
    end
    chk("R9 mem_req", 64'(mem_req), 64'(mpend));
    if (mpend) begin
      chk("R5 mem_addr", 64'(mem_addr), 64'(maddr));
      chk("R6 mem_we", 64'(mem_we), 64'(mwe));
      if (mwe) chk("R6 mem_wdata", 64'(mem_wdata), 64'(mwdata));
    end
  endtask

  task automatic step(bit v, int op, int i, int j, logic [17:0] d,
                      logic [59:0] x, bit ack, logic [59:0] rdv);
    bit kick, rdy, take;
    logic [17:0] an;
    req_valid = v; req_op = 2'(op); req_i = 3'(i); req_j = 3'(j);
    req_disp = d; req_data = x; mem_ack = ack; mem_rdata = rdv;
    #0.5;
    kick = (op >= 2) && (i != 0);
    rdy  = !mpend || !(kick || (op == 0 && !mwe && i == mtgt));
    chk("R8 req_ready", 64'(req_ready), 64'(rdy));
    take = v && rdy;
    an = ((op == 3) ? mb[j] : ma[j]) + d;
    if (mpend && ack) begin
      mpend = 0;
      if (!mwe) mx[mtgt] = rdv;
    end
    if (take) begin
      case (op)
        0: mx[i] = x;
        1: if (i != 0) mb[i] = mb[j] + d;
        default: ma[i] = an;
      endcase
      if (kick) begin
        mpend = 1; mtgt = i; maddr = an; mwe = (i >= 6); mwdata = mx[i];
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; mem_ack = 0;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 8; n++) begin mx[n] = 0; ma[n] = 0; mb[n] = 0; end
    mpend = 0; mwe = 0; mtgt = 0; maddr = 0; mwdata = 0;
    rst_n = 0; req_valid = 0; req_op = 0; req_i = 0; req_j = 0; req_disp = 0;
    req_data = 0; mem_ack = 0; mem_rdata = 0; rd_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    compare_all();
    #0.2 chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 mem_req after reset", 64'(mem_req), 64'd0);

    for (int n = 1; n < 8; n++) step(1, 0, n, 0, 0, 60'h0ABC_0000_0000_000 + 60'(n * 17), 0, 0);
    step(1, 1, 1, 0, 18'd100, 0, 0, 0);
    // R10 wrap: 100 + 0x3FFFF = 99
    step(1, 1, 2, 1, 18'h3FFFF, 0, 0, 0);
    rd_sel = 2; #0.2 chk("R10 wrapped index sum", 64'(rd_b), 64'd99);
    // R3 index 0 ignores writes
    step(1, 1, 0, 1, 18'd5, 0, 0, 0);
    rd_sel = 0; #0.2 chk("R3 index 0 stays zero", 64'(rd_b), 64'd0);
    // R7 A0 write, no transfer
    step(1, 3, 0, 1, 18'd5, 0, 0, 0);
    chk("R7 no transfer from A0", 64'(mem_req), 64'd0);
    // R5 load via A3
    step(1, 2, 3, 0, 18'd1, 0, 0, 0);
    chk("R5 load starts", 64'({mem_req, mem_we}), 64'b10);
    chk("R5 load address", 64'(mem_addr), 64'd106);
    // R8 stalls while pending
    step(1, 2, 4, 0, 18'd2, 0, 0, 0);
    step(1, 0, 3, 0, 0, 60'h123, 0, 0);
    step(1, 0, 2, 0, 0, 60'h456, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 60'hFEED_FACE);
    rd_sel = 3; #0.2 chk("R5 load data written", 64'(rd_x), 64'hFEED_FACE);
    // R6 store via A6
    step(1, 3, 6, 2, 18'd7, 0, 0, 0);
    chk("R6 store data", 64'(mem_wdata), 64'(mx[6]));
    step(0, 0, 0, 0, 0, 0, 1, 60'h777);
    chk("R9 released after ack", 64'(mem_req), 64'd0);
    // R10 wrap on address sum, store via A7
    step(1, 2, 7, 6, 18'h3FFFF, 0, 0, 0);
    chk("R10 wrapped store address", 64'(mem_addr), 64'd105);
    step(0, 0, 0, 0, 0, 0, 1, 0);

    for (int k = 0; k < 600; k++)
      step($urandom % 4 != 0, $urandom % 4, $urandom % 8, $urandom % 8, 18'($urandom),
           {28'($urandom), 32'($urandom)}, $urandom % 3 == 0, {28'($urandom), 32'($urandom)});

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule